// File: doc/BRIEF.md
# Supply Reset Supervisor with Margining Latch

This block turns three undervoltage flags into one active-low system reset. Each flag is high when its supply sits at or below its trip point. While any flag is high the reset output is driven low. Once all three flags have stayed clear for a whole timeout, the output goes high. The timeout is counted in clock cycles. A two-bit mode input selects its length: either a fixed internal count set by a parameter, or a count supplied on an input port.

The third mode value freezes the reset output. This lets the supplies be pushed outside their limits during margining without resetting the system. When the freeze is released, the block decides the next output from two things: the value that was frozen, and a settled view of supply validity. That view only accepts a validity value after it has held for a setup interval of cycles. Depending on those two inputs, the block does one of three things:

- keeps the output high,
- pulls it low after a short release delay, or
- runs a complete new timeout before letting it go high.

Top module: `supply_reset_supervisor`

## Requirements
- R1: Outside the freeze and outside a pending release delay, a clock edge that samples any `uv_flag` bit high drives `rst_out_n` low and clears the timeout count.
- R2: `rst_out_n` rises only at the edge that samples the L-th consecutive cycle with all flags clear, where L is the selected timeout length; a flag seen high during the count restarts it, and once high the output stays high while all flags stay clear.
- R3: `tmode` encoding: 2'b00 selects the freeze, 2'b01 selects the external length `ext_cycles` (a value of 0 acts as 1), and 2'b10 or 2'b11 selects the internal length INT_TIMEOUT.
- R4: While `tmode` is 2'b00, `rst_out_n` keeps the value it had at the edge before the freeze was sampled, whatever the flags do, and the timeout count is discarded.
- R5: At the first edge after the freeze (the release edge), if the output is high and the settled validity says all supplies are good, the output stays high and no timeout runs.
- R6: At the release edge, if the output is high and the settled validity says a supply is bad, the output goes low exactly REL_DLY edges after the release edge (REL_DLY is at least 1); no other change happens in between.
- R7: At the release edge, if the output is low, it stays low. If all supplies are then good, a complete fresh timeout starts with the following edge.
- R8: The settled validity follows the all-clear value only after that value has been sampled on SETUP consecutive edges, counting the current one. A shorter change is ignored at release.
- R9: While `por_n` is low, `rst_out_n` is low, the count is cleared and the freeze is cleared.
- R10: If the internal/external selection (bit 1 of `tmode`) differs from the previous edge while the output is low, the count restarts from zero at that edge and the new length applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| uv_flag | input | 3 | Undervoltage flags, one per supply, high = bad |
| tmode | input | 2 | Timer mode: 00 freeze, 01 external length, 1x internal length |
| ext_cycles | input | EXT_W | External timeout length in cycles |
| rst_out_n | output | 1 | System reset, active low |

## Verification
The critical overlap is a release edge that arrives while the monitored supplies are themselves changing. At that edge, both the frozen-state decision and the setup filter's view of validity apply. Directed sequences pulse a flag for fewer than SETUP cycles right before release, and separately restore all flags only two cycles before release. In each case the output is compared to a bench model that keeps its own run-length record of the sampled flags. Randomised segments also collide release edges with flag changes and with mode switches during counts.

// File: rtl/supply_reset_supervisor.sv
module supply_reset_supervisor #(
  parameter int INT_TIMEOUT = 1000,
  parameter int EXT_W       = 16,
  parameter int SETUP       = 64,
  parameter int REL_DLY     = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [2:0]       uv_flag,
  input  logic [1:0]       tmode,
  input  logic [EXT_W-1:0] ext_cycles,
  output logic             rst_out_n
);

  localparam int MAXT = (INT_TIMEOUT > (1 << EXT_W)) ? INT_TIMEOUT : (1 << EXT_W);
  localparam int CW   = $clog2(MAXT + 1);
  localparam int SW   = $clog2(SETUP + 1);
  localparam int PW   = $clog2(REL_DLY + 1);

  logic          ok, frz_now, sel_int, sel_q, ok_q, settled, settled_n, frz;
  logic [CW-1:0] cnt, lim;
  logic [SW-1:0] run, run_n;
  logic [PW-1:0] pend;

  assign ok      = ~|uv_flag;
  assign frz_now = (tmode == 2'b00);
  assign sel_int = tmode[1];
  assign lim     = sel_int ? CW'(INT_TIMEOUT)
                 : (ext_cycles == '0) ? CW'(1) : CW'(ext_cycles);

  assign run_n     = (ok != ok_q) ? SW'(1)
                   : (run == SW'(SETUP)) ? run : run + SW'(1);
  assign settled_n = (run_n == SW'(SETUP)) ? ok : settled;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ok_q    <= 1'b0;
      run     <= '0;
      settled <= 1'b0;
      sel_q   <= 1'b1;
    end else begin
      ok_q    <= ok;
      run     <= run_n;
      settled <= settled_n;
      sel_q   <= sel_int;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_out_n <= 1'b0;
      cnt       <= '0;
      frz       <= 1'b0;
      pend      <= '0;
    end else if (frz_now) begin
      frz  <= 1'b1;
      cnt  <= '0;
      pend <= '0;
    end else if (frz) begin
      frz <= 1'b0;
      cnt <= '0;
      if (rst_out_n && !settled_n) pend <= PW'(REL_DLY);
    end else if (pend != '0) begin
      if (pend == PW'(1)) rst_out_n <= 1'b0;
      pend <= pend - PW'(1);
    end else if (!ok) begin
      rst_out_n <= 1'b0;
      cnt       <= '0;
    end else if (!rst_out_n) begin
      if (sel_int != sel_q) begin
        cnt <= '0;
      end else if (cnt + CW'(1) >= lim) begin
        rst_out_n <= 1'b1;
        cnt       <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r1_invalid_pulls_low: assert property (@(posedge clk) disable iff (!por_n)
    (!frz_now && !frz && pend == '0 && uv_flag != 3'b000) |=> !rst_out_n);

  a_r2_rise_needs_valid: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> $past(uv_flag == 3'b000));

  a_r4_freeze_holds: assert property (@(posedge clk) disable iff (!por_n)
    frz_now |=> $stable(rst_out_n));

  a_r5_release_keeps_high: assert property (@(posedge clk) disable iff (!por_n)
    (frz && !frz_now && rst_out_n && settled_n) |=> rst_out_n);

  a_r6_delay_ends_low: assert property (@(posedge clk) disable iff (!por_n)
    (!frz_now && !frz && pend == PW'(1)) |=> !rst_out_n);

  a_r7_release_low_stays: assert property (@(posedge clk) disable iff (!por_n)
    (frz && !frz_now && !rst_out_n) |=> !rst_out_n);

endmodule

// File: tb/sim_supply_reset_supervisor.sv
module sim_supply_reset_supervisor;
  localparam int INT_T = 12;
  localparam int EW    = 5;
  localparam int SET   = 4;
  localparam int RD    = 2;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic [2:0]    uv_flag = 3'b000;
  logic [1:0]    tmode = 2'b11;
  logic [EW-1:0] ext_cycles = '0;
  logic          rst_out_n;

  always #5 clk = ~clk;

  supply_reset_supervisor #(.INT_TIMEOUT(INT_T), .EXT_W(EW), .SETUP(SET), .REL_DLY(RD)) u0 (
    .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .tmode(tmode),
    .ext_cycles(ext_cycles), .rst_out_n(rst_out_n));

  int checks = 0, errors = 0;
  bit done = 0;

  bit m_rst, m_frz, m_okq, m_set, m_sel;
  int m_cnt, m_pend, m_run;
  string m_why;

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: rst_out_n actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_rst = 0; m_frz = 0; m_okq = 0; m_set = 0; m_sel = 1;
    m_cnt = 0; m_pend = 0; m_run = 0; m_why = "R9";
  endtask

  function automatic int lim_of(input logic [1:0] tm, input logic [EW-1:0] ex);
    if (tm[1]) return INT_T;
    return (ex == 0) ? 1 : int'(ex);
  endfunction

  task automatic model_step();
    bit ok, set_n;
    int run_n;
    ok = (uv_flag == 3'b000);
    run_n = (ok != m_okq) ? 1 : ((m_run == SET) ? m_run : m_run + 1);
    set_n = (run_n == SET) ? ok : m_set;
    if (tmode == 2'b00) begin
      m_frz = 1; m_cnt = 0; m_pend = 0; m_why = "R4";
    end else if (m_frz) begin
      m_frz = 0; m_cnt = 0;
      if (m_rst) begin
        if (set_n) m_why = "R5";
        else begin m_pend = RD; m_why = "R6"; end
      end else m_why = "R7";
      if (set_n != ok) m_why = "R8";
    end else if (m_pend != 0) begin
      if (m_pend == 1) m_rst = 0;
      m_pend--; m_why = "R6";
    end else if (!ok) begin
      m_rst = 0; m_cnt = 0; m_why = "R1";
    end else if (!m_rst) begin
      if (tmode[1] != m_sel) begin
        m_cnt = 0; m_why = "R10";
      end else if (m_cnt + 1 >= lim_of(tmode, ext_cycles)) begin
        m_rst = 1; m_cnt = 0; m_why = "R3";
      end else begin
        m_cnt++; m_why = "R2";
      end
    end else m_why = "R2";
    m_okq = ok; m_run = run_n; m_set = set_n; m_sel = tmode[1];
  endtask

  task automatic cyc(input logic [2:0] u, input logic [1:0] tm, input logic [EW-1:0] ex);
    uv_flag = u; tmode = tm; ext_cycles = ex;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(rst_out_n == m_rst, m_why, rst_out_n, m_rst);
  endtask

  task automatic do_reset();
    por_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    chk(rst_out_n == 1'b0, "R9", rst_out_n, 0);
    por_n = 1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2911));
    @(negedge clk);
    do_reset();

    // R2: internal length, exact edge of rise
    begin
      int n = 0;
      while (rst_out_n == 1'b0 && n < 50) begin
        cyc(3'b000, 2'b11, 0);
        n++;
      end
      chk(n == INT_T, "R2", n, INT_T);
    end

    // R1 then R3 external length with glitch, and zero length
    cyc(3'b010, 2'b01, 5);
    repeat (3) cyc(3'b000, 2'b01, 5);
    cyc(3'b001, 2'b01, 5);
    repeat (6) cyc(3'b000, 2'b01, 5);
    cyc(3'b100, 2'b01, 0);
    cyc(3'b000, 2'b01, 0);
    chk(rst_out_n == 1'b1, "R3", rst_out_n, 1);

    // R10: switch selection mid count
    cyc(3'b100, 2'b01, 8);
    repeat (4) cyc(3'b000, 2'b01, 8);
    repeat (INT_T + 2) cyc(3'b000, 2'b10, 8);

    // R4/R5: freeze while high, supplies sag, valid at release
    repeat (6) cyc(3'b111, 2'b00, 0);
    repeat (SET) cyc(3'b000, 2'b00, 0);
    cyc(3'b000, 2'b11, 0);
    chk(rst_out_n == 1'b1, "R5", rst_out_n, 1);

    // R8: short pulse just before release is ignored
    repeat (SET) cyc(3'b000, 2'b00, 0);
    repeat (SET - 2) cyc(3'b010, 2'b00, 0);
    cyc(3'b000, 2'b11, 0);
    cyc(3'b000, 2'b11, 0);
    chk(rst_out_n == 1'b1, "R8", rst_out_n, 1);

    // R6/R8: long invalid, restored two cycles before release
    repeat (SET + 2) cyc(3'b001, 2'b00, 0);
    repeat (2) cyc(3'b000, 2'b00, 0);
    cyc(3'b000, 2'b11, 0);
    for (int i = 1; i < RD; i++) cyc(3'b000, 2'b11, 0);
    chk(rst_out_n == 1'b1, "R6", rst_out_n, 1);
    cyc(3'b000, 2'b11, 0);
    chk(rst_out_n == 1'b0, "R6", rst_out_n, 0);

    // R7: freeze while low, release valid, full fresh timeout
    repeat (5) cyc(3'b000, 2'b11, 0);
    repeat (SET + 3) cyc(3'b000, 2'b00, 0);
    begin
      int n = 0;
      cyc(3'b000, 2'b11, 0);
      while (rst_out_n == 1'b0 && n < 50) begin
        cyc(3'b000, 2'b11, 0);
        n++;
      end
      chk(n == INT_T, "R7", n, INT_T);
    end

    // random segments
    for (int s = 0; s < 700; s++) begin
      int len = 1 + int'($urandom % 30);
      int r = int'($urandom % 8);
      logic [1:0] tm = (r < 2) ? 2'b00 : (r < 5) ? 2'b01 : {1'b1, 1'($urandom)};
      logic [EW-1:0] ex = EW'($urandom % 20);
      bit bad = ($urandom % 5 == 0);
      if (s == 350) do_reset();
      for (int k = 0; k < len; k++) begin
        logic [2:0] u = 3'b000;
        if (bad || ($urandom % 10 == 0)) u = 3'(1 + $urandom % 7);
        cyc(u, tm, ex);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule